// File: doc/BRIEF.md
# Event-Triggered Programmable Pulse Generator

This block sits on the receive side of an event timing link. A stream of 8-bit event codes arrives, at most one per clock, each qualified by a valid strobe. Each code indexes a host-written mapping table. The table returns a bitmask that names the trigger channels this code starts. Every channel owns a long-range delay counter and a pulse-width counter, so one broadcast code can fire many outputs, each at its own offset.

Each channel has three settings: a delay in whole clock periods, a pulse width in whole clock periods, and an output polarity. A channel also has an enable bit. When the bit is clear, the channel is held quiet. A channel that is already busy ignores further matching codes and counts them in a per-channel overlap counter. The host programs the table and the channel settings through one write port.

Top module: `evt_trig_pulser`

## Requirements
- R1: After reset every channel is disabled with delay 0, width 0 and polarity active-high, every mapping entry is zero, every trig_out bit is 0 and every overlap counter is 0.
- R2: A host write with host_addr[8]=1 stores host_wdata[13:0] as the channel mask of event code host_addr[7:0]. A write with host_addr[8]=0 targets channel host_addr[3:0], and host_addr[5:4] picks the field: 0 is the 32-bit delay, 1 is the width (host_wdata[15:0]), 2 is control (bit 0 enable, bit 1 active-low). A field value of 3 changes nothing.
- R3: An idle, enabled channel hit by a code received in cycle t with delay D becomes active in cycle t+1+D. D=0 gives activity in cycle t+1.
- R4: The active phase lasts W cycles for a width setting W of 1 or more. A width setting of 0 lasts one cycle.
- R5: With the active-low bit set, the output is 0 while active and 1 otherwise. With the bit clear, the output is 1 while active and 0 otherwise.
- R6: One code starts every channel whose bit is set in its mask, all at once. Channels whose bit is clear do not respond.
- R7: Event code 0x00 starts no channel, whatever its mapping entry holds.
- R8: A matching code that reaches a channel in its delay or active phase does not change that channel's timing. It adds one to that channel's 8-bit overlap counter, which stops at 255.
- R9: While a channel is disabled, its output sits at its inactive level, it ignores codes, and its counters, the overlap counter included, are held at zero.
- R10: A code presented while evt_valid is 0 starts no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Qualifies evt_code this cycle |
| evt_code | input | 8 | Received event code |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host write address (table or channel field) |
| host_wdata | input | 32 | Host write data |
| trig_out | output | 14 | Trigger outputs, one per channel |
| ovl_cnt | output | 112 | Overlap counters, 8 bits per channel, channel 0 in the low bits |

## Verification
A sweep on one channel covers every delay from 0 to 4 with every width from 0 to 3, and the polarity alternates between runs. This separates off-by-one errors in the start cycle from those in the pulse length, and shows whether a zero width is handled. A code mapped to all fourteen channels, each with a different delay, width and polarity, produces a staggered pattern. A sparse mask then shows that decoding is per channel and that unmapped outputs stay still. Separate runs cover code zero, a low valid strobe, a delay of 1000, a repeated code inside a running delay, and disabling a channel. These show that each ignored stimulus leaves the outputs and counters untouched.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;
    localparam int CODE_W  = 8;
    localparam int DLY_W   = 32;
    localparam int WID_W   = 16;
    localparam int HOST_DW = 32;
    localparam int HA_W    = CODE_W + 1;

    typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_FIRE} ch_state_e;
    typedef enum logic [1:0] {FLD_DELAY = 2'd0, FLD_WIDTH = 2'd1,
                              FLD_CTRL = 2'd2, FLD_NONE = 2'd3} cfg_field_e;

    typedef struct packed {
        logic [DLY_W-1:0] delay;
        logic [WID_W-1:0] width;
        logic             enable;
        logic             invert;
    } ch_cfg_t;

    // Counter preload for the active phase; a zero width counts as one cycle.
    function automatic logic [DLY_W-1:0] width_load(input logic [WID_W-1:0] w);
        return (w == '0) ? '0 : DLY_W'(w) - DLY_W'(1);
    endfunction
endpackage

// File: rtl/evt_map_mem.sv
module evt_map_mem
    import evt_trig_pkg::*;
#(
    parameter int NUM_CH = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CODE_W-1:0]    wr_addr,
    input  logic [NUM_CH-1:0]    wr_mask,
    input  logic                 code_valid,
    input  logic [CODE_W-1:0]    code,
    output logic [NUM_CH-1:0]    hit
);
    localparam int DEPTH = 2 ** CODE_W;

    logic [NUM_CH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_mask;
        end
    end

    always_comb begin
        hit = '0;
        if (code_valid && code != '0) hit = mem[code];
    end

    // R2: a table write lands in the addressed entry
    a_r2_map_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_mask));
endmodule

// File: rtl/evt_trig_chan.sv
module evt_trig_chan
    import evt_trig_pkg::*;
#(
    parameter int OVL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  cfg_field_e         cfg_field,
    input  logic [HOST_DW-1:0] cfg_wdata,
    input  logic               hit,
    output logic               pulse,
    output logic               busy,
    output logic [OVL_W-1:0]   ovl
);
    ch_cfg_t          cfg;
    ch_state_e        state;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_we) begin
            case (cfg_field)
                FLD_DELAY: cfg.delay  <= cfg_wdata[DLY_W-1:0];
                FLD_WIDTH: cfg.width  <= cfg_wdata[WID_W-1:0];
                FLD_CTRL: begin
                    cfg.enable <= cfg_wdata[0];
                    cfg.invert <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.enable) begin
            state <= CH_IDLE;
            cnt   <= '0;
            ovl   <= '0;
        end else begin
            case (state)
                CH_IDLE: if (hit) begin
                    if (cfg.delay == '0) begin
                        state <= CH_FIRE;
                        cnt   <= width_load(cfg.width);
                    end else begin
                        state <= CH_WAIT;
                        cnt   <= cfg.delay - DLY_W'(1);
                    end
                end
                CH_WAIT: if (cnt == '0) begin
                    state <= CH_FIRE;
                    cnt   <= width_load(cfg.width);
                end else begin
                    cnt <= cnt - DLY_W'(1);
                end
                CH_FIRE: if (cnt == '0) state <= CH_IDLE;
                         else cnt <= cnt - DLY_W'(1);
                default: state <= CH_IDLE;
            endcase
            if (hit && state != CH_IDLE && ovl != '1) ovl <= ovl + OVL_W'(1);
        end
    end

    assign busy  = (state != CH_IDLE);
    assign pulse = (state == CH_FIRE && cfg.enable) ^ cfg.invert;

    // R3: an expired delay always leads into the active phase
    a_r3_wait_to_fire: assert property (@(posedge clk) disable iff (rst)
        (state == CH_WAIT && cnt == '0 && cfg.enable) |=> state == CH_FIRE);
    // R4: the active phase continues while cycles remain
    a_r4_fire_holds: assert property (@(posedge clk) disable iff (rst)
        (state == CH_FIRE && cnt != '0 && cfg.enable) |=> state == CH_FIRE);
    // R8: a code arriving while busy bumps the overlap counter by one
    a_r8_ovl_step: assert property (@(posedge clk) disable iff (rst)
        (hit && busy && cfg.enable && ovl != '1) |=> ovl == $past(ovl) + OVL_W'(1));
    // R9: a disabled channel is idle with a cleared overlap counter
    a_r9_disabled_clear: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> (state == CH_IDLE && ovl == '0));
endmodule

// File: rtl/evt_trig_pulser.sv
module evt_trig_pulser
    import evt_trig_pkg::*;
#(
    parameter int NUM_CH = 14,
    parameter int OVL_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    evt_valid,
    input  logic [CODE_W-1:0]       evt_code,
    input  logic                    host_we,
    input  logic [HA_W-1:0]         host_addr,
    input  logic [HOST_DW-1:0]      host_wdata,
    output logic [NUM_CH-1:0]       trig_out,
    output logic [NUM_CH*OVL_W-1:0] ovl_cnt
);
    localparam int CH_W = $clog2(NUM_CH);

    logic              map_we;
    logic [CH_W-1:0]   ch_sel;
    cfg_field_e        field;
    logic [NUM_CH-1:0] hit_vec;
    logic [NUM_CH-1:0] busy_vec;

    assign map_we = host_we && host_addr[HA_W-1];
    assign ch_sel = host_addr[CH_W-1:0];
    assign field  = cfg_field_e'(host_addr[CH_W+1:CH_W]);

    evt_map_mem #(.NUM_CH(NUM_CH)) u_map (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (map_we),
        .wr_addr    (host_addr[CODE_W-1:0]),
        .wr_mask    (host_wdata[NUM_CH-1:0]),
        .code_valid (evt_valid),
        .code       (evt_code),
        .hit        (hit_vec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = host_we && !host_addr[HA_W-1] && (ch_sel == CH_W'(i));
        evt_trig_chan #(.OVL_W(OVL_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (sel),
            .cfg_field (field),
            .cfg_wdata (host_wdata),
            .hit       (hit_vec[i]),
            .pulse     (trig_out[i]),
            .busy      (busy_vec[i]),
            .ovl       (ovl_cnt[i*OVL_W +: OVL_W])
        );
    end

    // R7: code zero never wakes an idle receiver
    a_r7_zero_code: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == '0 && busy_vec == '0) |=> busy_vec == '0);
    // R10: with no valid strobe nothing leaves idle
    a_r10_no_valid: assert property (@(posedge clk) disable iff (rst)
        (!evt_valid && busy_vec == '0) |=> busy_vec == '0);
endmodule

// File: tb/tb_evt_trig_pulser.sv
module tb_evt_trig_pulser;
    localparam int NCH = 14;

    logic         clk = 0;
    logic         rst = 1;
    logic         evt_valid = 0;
    logic [7:0]   evt_code = 0;
    logic         host_we = 0;
    logic [8:0]   host_addr = 0;
    logic [31:0]  host_wdata = 0;
    logic [NCH-1:0]   trig_out;
    logic [NCH*8-1:0] ovl_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [NCH-1:0] b_map [256];
    int             b_dly [NCH];
    int             b_wid [NCH];
    bit             b_en  [NCH];
    bit             b_inv [NCH];

    evt_trig_pulser dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .trig_out(trig_out), .ovl_cnt(ovl_cnt)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic set_ch(input int ch, input int d, input int w, input bit en, input bit inv);
        host_wr(9'((0 << 4) | ch), 32'(d));
        host_wr(9'((1 << 4) | ch), 32'(w));
        host_wr(9'((2 << 4) | ch), {30'd0, inv, en});
        b_dly[ch] = d; b_wid[ch] = w; b_en[ch] = en; b_inv[ch] = inv;
    endtask

    task automatic set_map(input int code, input logic [NCH-1:0] m);
        host_wr(9'h100 | 9'(code), 32'(m));
        b_map[code] = m;
    endtask

    // Expected outputs j negedges after a code was driven (one event, all idle before)
    function automatic logic [NCH-1:0] exp_vec(input int code, input bit vld, input int j);
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) begin
            int wef = (b_wid[c] == 0) ? 1 : b_wid[c];
            bit act = vld && b_en[c] && code != 0 && b_map[code][c] &&
                      j >= 1 + b_dly[c] && j <= b_dly[c] + wef;
            v[c] = act ^ b_inv[c];
        end
        return v;
    endfunction

    task automatic run_event(input int code, input bit vld, input int len, input string tag);
        bit ok = 1;
        logic [NCH-1:0] a_bad = 0, e_bad = 0;
        @(negedge clk);
        evt_valid = vld; evt_code = 8'(code);
        for (int j = 1; j <= len; j++) begin
            @(negedge clk);
            evt_valid = 0;
            if (ok && trig_out !== exp_vec(code, vld, j)) begin
                ok = 0; a_bad = trig_out; e_bad = exp_vec(code, vld, j);
            end
        end
        check(ok, tag, 32'(a_bad), 32'(e_bad));
    endtask

    initial begin
        for (int k = 0; k < 256; k++) b_map[k] = '0;
        for (int c = 0; c < NCH; c++) begin
            b_dly[c] = 0; b_wid[c] = 0; b_en[c] = 0; b_inv[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(trig_out == '0, "R1 reset outputs", 32'(trig_out), 0);
        check(ovl_cnt == '0, "R1 reset overlap counters", 32'(ovl_cnt[31:0]), 0);
        run_event(8'h11, 1, 8, "R1 reset table and disabled channels give no output");

        // R3 R4 R5: delay/width/polarity sweep on channel 0 (R2 encoding in use)
        set_map(8'h11, 14'h0001);
        for (int d = 0; d <= 4; d++) begin
            for (int w = 0; w <= 3; w++) begin
                set_ch(0, d, w, 1, bit'((d + w) % 2));
                run_event(8'h11, 1, d + ((w == 0) ? 1 : w) + 3,
                          $sformatf("R3 R4 R5 ch0 delay %0d width %0d", d, w));
            end
        end

        // R6: one code, all channels, staggered settings
        for (int c = 0; c < NCH; c++) set_ch(c, c, 1 + (c % 3), 1, bit'(c % 2));
        set_map(8'hA5, 14'h3FFF);
        run_event(8'hA5, 1, 20, "R6 all channels staggered");
        set_map(8'h3C, 14'h2212);
        run_event(8'h3C, 1, 20, "R6 sparse mask channels 1 4 9 13");

        // R2: field 3 write changes nothing
        host_wr(9'((3 << 4) | 1), 32'hFFFF_FFFF);
        run_event(8'h3C, 1, 20, "R2 field 3 write ignored");

        // R7: code zero with a full mapping entry
        set_map(0, 14'h3FFF);
        run_event(0, 1, 20, "R7 code zero ignored");
        // R10: valid low
        run_event(8'hA5, 0, 20, "R10 valid low ignored");

        // R3: long delay
        set_ch(5, 1000, 3, 1, 0);
        set_map(8'h77, 14'h0020);
        run_event(8'h77, 1, 1008, "R3 delay 1000");

        // R8: repeated code during delay; ch3 disabled active-low (R9)
        set_ch(2, 5, 2, 1, 0);
        set_ch(3, 0, 1, 0, 1);
        set_map(8'h21, 14'h000C);
        begin
            bit ok = 1;
            logic [NCH-1:0] a_bad = 0, e_bad = 0;
            @(negedge clk);
            evt_valid = 1; evt_code = 8'h21;
            for (int j = 1; j <= 12; j++) begin
                @(negedge clk);
                if (j >= 2) evt_valid = 0;
                if (ok && trig_out !== exp_vec(8'h21, 1, j)) begin
                    ok = 0; a_bad = trig_out; e_bad = exp_vec(8'h21, 1, j);
                end
            end
            check(ok, "R8 R9 second code keeps first timing, disabled ch3 held high",
                  32'(a_bad), 32'(e_bad));
        end
        check(ovl_cnt[2*8 +: 8] == 8'd1, "R8 overlap count ch2", 32'(ovl_cnt[2*8 +: 8]), 1);
        check(ovl_cnt[3*8 +: 8] == 8'd0, "R9 disabled ch3 overlap", 32'(ovl_cnt[3*8 +: 8]), 0);

        // R9: disabling clears the overlap counter and holds inactive level
        set_ch(2, 5, 2, 0, 0);
        @(negedge clk);
        check(ovl_cnt[2*8 +: 8] == 8'd0, "R9 disable clears overlap", 32'(ovl_cnt[2*8 +: 8]), 0);
        run_event(8'h21, 1, 10, "R9 disabled channels ignore code");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule